// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block corrects an 8-bit accumulator after a binary add or subtract of two packed BCD bytes, so that the result is again two valid decimal digits. It takes the accumulator and the flag byte produced by that arithmetic. It reads three flags: carry, half-carry and subtract. It returns the corrected accumulator and a rebuilt flag byte. The correction value is 0x60 for the upper digit, 0x06 for the lower digit, or both. The subtract flag decides whether the correction is added or removed.

The correction logic is purely combinational. A parameterised register chain delays the result, so the unit fits a processor that gives the operation a fixed cost in cycles. With the default depth of four, a request issued with `in_valid` appears on the outputs four clock edges later. A new request may be issued on every cycle. A depth of zero gives a purely combinational path.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The flag byte layout is: bit 0 carry, bit 1 subtract, bit 2 parity, bit 3 copy of result bit 3, bit 4 half-carry, bit 5 copy of result bit 5, bit 6 zero, bit 7 sign. With subtract clear, an accumulator above 0x99 gets 0x60 added and carry set in the output.
- R2: When the incoming carry is 1, the upper correction 0x60 is applied whatever the accumulator value, and carry stays 1.
- R3: The lower correction is decided after the upper one, on the low nibble of the already-corrected value. If half-carry is 1 or that nibble exceeds 9, 0x06 is applied, and in the second case half-carry is set.
- R4: With subtract set, the same conditions apply, but each correction is subtracted instead of added. All arithmetic wraps modulo 256.
- R5: Carry and half-carry in the output are the incoming values ORed with any set by the corrections, so they are never cleared. The subtract bit passes through unchanged.
- R6: The sign bit equals result bit 7. The zero bit is 1 exactly when the result is 0x00.
- R7: The parity bit is 1 when the result has an even number of one bits.
- R8: Output flag bits 3 and 5 equal result bits 3 and 5.
- R9: With LAT=4, a request sampled with in_valid on a clock edge produces out_valid and its result after exactly four edges. Back-to-back requests come out in order, one per cycle.
- R10: While reset is asserted, and on the first edge after it is released, out_valid, acc_out and flags_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output chain |
| in_valid | input | 1 | Request marker for the current operand |
| acc_in | input | 8 | Accumulator after the BCD add or subtract |
| flags_in | input | 8 | Flag byte after that add or subtract |
| out_valid | output | 1 | Result marker, delayed by LAT cycles |
| acc_out | output | 8 | Corrected accumulator |
| flags_out | output | 8 | Rebuilt flag byte |

## Verification
The upper and lower corrections can both fire on the same operand. In that case the lower decision must see the value left by the upper one. The bench provokes this with operands such as 0x9A and 0xFF, and with incoming carry together with a nibble near the 9/10 boundary. It also sweeps all 256 accumulator values against every combination of carry, half-carry and subtract. Every result is judged against a behavioural step-by-step model, whose expected values are kept in a queue, on each clock. The issue-to-result distance is checked for every request, while requests stream back to back.

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic [7:0] flags_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic [7:0] flags_out
);
  localparam int BIT_C = 0;
  localparam int BIT_N = 1;
  localparam int BIT_P = 2;
  localparam int BIT_H = 4;
  localparam int BIT_Z = 6;
  localparam int BIT_S = 7;

  logic       sub, hi_fix, lo_fix;
  logic [7:0] hi_amt, lo_amt, mid, res, res_flags;

  assign sub    = flags_in[BIT_N];
  assign hi_fix = flags_in[BIT_C] | (acc_in > 8'h99);
  assign hi_amt = hi_fix ? 8'h60 : 8'h00;
  assign mid    = sub ? acc_in - hi_amt : acc_in + hi_amt;
  assign lo_fix = flags_in[BIT_H] | (mid[3:0] > 4'd9);
  assign lo_amt = lo_fix ? 8'h06 : 8'h00;
  assign res    = sub ? mid - lo_amt : mid + lo_amt;

  always_comb begin
    res_flags        = 8'h00;
    res_flags[BIT_C] = hi_fix;
    res_flags[BIT_N] = sub;
    res_flags[BIT_P] = ~^res;
    res_flags[3]     = res[3];
    res_flags[BIT_H] = lo_fix;
    res_flags[5]     = res[5];
    res_flags[BIT_Z] = (res == 8'h00);
    res_flags[BIT_S] = res[7];
  end

  generate
    if (LAT == 0) begin : g_comb
      assign out_valid = in_valid;
      assign acc_out   = res;
      assign flags_out = res_flags;
    end else begin : g_pipe
      logic       vld_q [LAT];
      logic [7:0] acc_q [LAT];
      logic [7:0] flg_q [LAT];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT; i++) begin
            vld_q[i] <= 1'b0;
            acc_q[i] <= 8'h00;
            flg_q[i] <= 8'h00;
          end
        end else begin
          vld_q[0] <= in_valid;
          acc_q[0] <= res;
          flg_q[0] <= res_flags;
          for (int i = 1; i < LAT; i++) begin
            vld_q[i] <= vld_q[i-1];
            acc_q[i] <= acc_q[i-1];
            flg_q[i] <= flg_q[i-1];
          end
        end
      end

      assign out_valid = vld_q[LAT-1];
      assign acc_out   = acc_q[LAT-1];
      assign flags_out = flg_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic [7:0] acc_out,
  input logic [7:0] flags_out
);
  assert_sign_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[7] == acc_out[7]) && (flags_out[6] == (acc_out == 8'h00)));

  assert_even_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[2] == ~^acc_out));

  assert_copy_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[3] == acc_out[3]) && (flags_out[5] == acc_out[5]));

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && (flags_out == 8'h00));

  assert_decimal_excess_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flags_out[1] && !flags_out[0]) |-> (acc_out <= 8'h99 || flags_out[4]));
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (.*);

// File: tb/tb_bcd_adjust_unit.sv
`timescale 1ns/1ps
module tb_bcd_adjust_unit;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] flags_in = 8'h00;
  logic       out_valid;
  logic [7:0] acc_out, flags_out;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int    q_acc[$], q_flg[$], q_t[$];
  string q_tag[$];

  bcd_adjust_unit #(.LAT(LAT)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model_adjust(input int a, input int f, output int ra, output int rf);
    int c, h, n, v, ones;
    c = f & 1; h = (f >> 4) & 1; n = (f >> 1) & 1; v = a;
    if (c == 1 || v > 153) begin v = (n == 1) ? v - 96 : v + 96; c = 1; end
    v = v & 255;
    if (h == 1 || (v % 16) > 9) begin v = (n == 1) ? v - 6 : v + 6; h = 1; end
    v = v & 255;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (v >> k) & 1;
    ra = v;
    rf = ((v >= 128) ? 128 : 0) | ((v == 0) ? 64 : 0) | (v & 40) | (h << 4)
       | (((ones % 2) == 0) ? 4 : 0) | (n << 1) | c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int a, input int f, input string tag);
    int ra, rf;
    @(negedge clk);
    in_valid = 1'b1; acc_in = a[7:0]; flags_in = f[7:0];
    model_adjust(a, f, ra, rf);
    q_acc.push_back(ra); q_flg.push_back(rf); q_t.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_acc.size() == 0) begin
        check("R9 unexpected out_valid", 1, 0);
      end else begin
        int ea, ef, et;
        string tg;
        ea = q_acc.pop_front(); ef = q_flg.pop_front(); et = q_t.pop_front(); tg = q_tag.pop_front();
        check({tg, " accumulator"}, acc_out, ea);
        check("R5 carry/half-carry/subtract", flags_out & 8'h13, ef & 8'h13);
        check("R6 sign/zero", flags_out & 8'hC0, ef & 8'hC0);
        check("R7 parity", flags_out[2], (ef >> 2) & 1);
        check("R8 bits 3 and 5", flags_out & 8'h28, ef & 8'h28);
        check("R9 latency", cyc - et, LAT);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", out_valid, 0);
    check("R10 flags_out in reset", flags_out, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 out_valid after release", out_valid, 0);
    check("R10 acc_out after release", acc_out, 0);

    issue(8'h9A, 8'h00, "R1 both corrections add");
    issue(8'hA5, 8'h00, "R1 upper only add");
    issue(8'h15, 8'h01, "R2 carry in forces upper");
    issue(8'h09, 8'h01, "R2 carry in low value");
    issue(8'h2C, 8'h00, "R3 low nibble over 9");
    issue(8'h31, 8'h10, "R3 half-carry in");
    issue(8'h99, 8'h00, "R3 no correction edge");
    issue(8'h9F, 8'h00, "R3 updated value decides");
    issue(8'hFF, 8'h00, "R3 both wrap");
    idle(2);
    issue(8'h3C, 8'h02, "R4 subtract low");
    issue(8'hF5, 8'h03, "R4 subtract carry");
    issue(8'h00, 8'h13, "R4 subtract wrap");
    issue(8'h45, 8'h12, "R4 subtract half");
    issue(8'h42, 8'h11, "R5 sticky flags");
    issue(8'h9A, 8'h02, "R4 subtract both");
    idle(LAT + 2);
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 8; fl++)
        issue(a, ((fl & 1) ? 8'h01 : 0) | ((fl & 2) ? 8'h10 : 0) | ((fl & 4) ? 8'h02 : 0),
              "R1 R3 R4 sweep");
    idle(LAT + 3);
    check("R9 all results delivered", q_acc.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule